// File: doc/BRIEF.md
# Partitioned-way cache tag controller with recency accounting

This block is the tag-side control of a 4-way set-associative cache whose ways are split into a fast primary group and a slower secondary group. The primary group always holds the k most recently used blocks of a set, where k is 1 to 4. The secondary group holds the remaining 4-k blocks. A lookup first checks the primary group. When that check misses and the secondary group is enabled, the secondary group is checked next. A secondary hit moves the block into the primary group by promoting it to most-recently-used; the primary group's least recent block drops into the secondary group in its place. When the secondary group is disabled, a primary miss is reported as a plain miss and goes to the next memory level.

Each set keeps a full recency order of its four ways. Every lookup that matches a tag is counted against the recency position it matched, whatever the current split. Every lookup that matches no tag is counted as a miss. These five counts are enough to compute, for each candidate k, how many lookups would have hit the primary group, how many the secondary group, and how many would have missed. When the interval-end input is pulsed, the block applies a latency cost model to each candidate, loads the cheapest k as the new primary size, and clears the counts.

Top module: `acct_cache_ctrl`

## Requirements
- R1: After reset, `a_ways` is 1, `rsp_valid` is 0, every way of every set is invalid, and the recency order of each set is way 0, 1, 2, 3 from most recent to least recent.
- R2: A lookup that matches a valid tag at recency position p, where p < `a_ways`, gives a response one cycle later with `rsp_hit_a`=1, `rsp_pos`=p and `rsp_way` set to the matching way. Each response asserts exactly one of `rsp_hit_a`, `rsp_hit_b` and `rsp_miss`.
- R3: If `a_only`=0, a lookup that matches at position p >= `a_ways` responds with `rsp_hit_b`=1 and `rsp_pos`=p.
- R4: If `a_only`=1, a lookup that matches at position p >= `a_ways` responds with `rsp_miss`=1 and `rsp_pos`=p. The block is still promoted and counted at p.
- R5: A lookup that matches no valid tag responds with `rsp_miss`=1 and `rsp_pos`=3. It writes its tag into the way at position 3, the least recently used way, and marks that way valid.
- R6: After every lookup, the way it used, whether hit or victim, becomes position 0. The ways that were ahead of it move back by one position, and the ways behind it keep their positions.
- R7: When `interval_end` is high at a clock edge, `a_ways` takes the value k in 1..4 that minimises the cost H_A(k)·LA[k] + H_B(k)·(LA[k]+LB[k]) + M·MISS_PEN, using the counts held before that edge. H_A(k) is the sum of the position counts below k, H_B(k) is the sum of the rest, and LB[4] is 0. Ties go to the smaller k. At all other edges, `a_ways` keeps its value.
- R8: At an interval-end edge the counts are cleared. A lookup made in that same cycle is counted into the new interval.
- R9: Each position count and the miss count is 16 bits wide and stops at 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_set | input | SET_W | Set index of the lookup |
| lk_tag | input | TAG_W | Tag of the lookup |
| a_only | input | 1 | Disable the secondary probe |
| interval_end | input | 1 | Close the accounting interval and reselect the primary size |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit_a | output | 1 | Hit in the primary group |
| rsp_hit_b | output | 1 | Hit in the secondary group, block promoted |
| rsp_miss | output | 1 | Miss, to be filled from the next level |
| rsp_way | output | 2 | Way that hit, or the way chosen as victim |
| rsp_pos | output | 2 | Recency position matched, or 3 on a miss |
| a_ways | output | 3 | Current primary group size, 1 to 4 |

## Verification
The situation hardest to reach from the ports is count saturation. A single interval must carry more than 65535 lookups at one position before the clipped count changes which primary size is chosen. The bench therefore repeats a single tag about 70000 times, which piles hits at position 0. It then alternates two tags in one set, which gives about 2000 hits at position 1. With these counts a saturating counter selects one way, while a wrapping counter would select two. Tie-breaking and clearing are checked by closing an interval that has no lookups, where every candidate costs zero.

// File: rtl/acct_cache_ctrl.sv
module acct_cache_ctrl #(
  parameter int SET_W    = 4,
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 16,
  parameter int A_LAT1   = 2,
  parameter int A_LAT2   = 3,
  parameter int A_LAT3   = 4,
  parameter int A_LAT4   = 5,
  parameter int B_LAT1   = 8,
  parameter int B_LAT2   = 5,
  parameter int B_LAT3   = 2,
  parameter int MISS_PEN = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             a_only,
  input  logic             interval_end,
  output logic             rsp_valid,
  output logic             rsp_hit_a,
  output logic             rsp_hit_b,
  output logic             rsp_miss,
  output logic [1:0]       rsp_way,
  output logic [1:0]       rsp_pos,
  output logic [2:0]       a_ways
);
  localparam int SETS = 1 << SET_W;
  localparam int LA [4] = '{A_LAT1, A_LAT2, A_LAT3, A_LAT4};
  localparam int LB [4] = '{B_LAT1, B_LAT2, B_LAT3, 0};

  logic [TAG_W-1:0] tag_q [SETS][4];
  logic [3:0]       vld_q [SETS];
  logic [1:0]       ord_q [SETS][4];
  logic [CNT_W-1:0] cnt_q [5];

  logic       hit, in_a;
  logic [1:0] hway, hpos, tgt_way, tgt_pos;
  logic [1:0] new_ord [4];
  logic [2:0] inc_idx, best_k;

  always_comb begin
    hit = 1'b0;
    hway = 2'd0;
    hpos = 2'd0;
    for (int w = 0; w < 4; w++)
      if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        hit = 1'b1;
        hway = 2'(w);
      end
    for (int p = 0; p < 4; p++)
      if (ord_q[lk_set][p] == hway) hpos = 2'(p);
  end

  assign tgt_way = hit ? hway : ord_q[lk_set][3];
  assign tgt_pos = hit ? hpos : 2'd3;
  assign in_a    = {1'b0, hpos} < a_ways;
  assign inc_idx = hit ? {1'b0, hpos} : 3'd4;

  always_comb begin
    new_ord[0] = tgt_way;
    for (int p = 1; p < 4; p++)
      new_ord[p] = (2'(p) <= tgt_pos) ? ord_q[lk_set][p-1] : ord_q[lk_set][p];
  end

  always_comb begin
    logic [47:0] ah, bh, c, best_c;
    best_k = 3'd1;
    best_c = '0;
    for (int k = 0; k < 4; k++) begin
      ah = '0;
      bh = '0;
      for (int p = 0; p < 4; p++)
        if (p <= k) ah = ah + 48'(cnt_q[p]);
        else        bh = bh + 48'(cnt_q[p]);
      c = ah * 48'(LA[k]) + bh * 48'(LA[k] + LB[k]) + 48'(cnt_q[4]) * 48'(MISS_PEN);
      if (k == 0 || c < best_c) begin
        best_c = c;
        best_k = 3'(k + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < 4; w++) begin
          ord_q[s][w] <= 2'(w);
          tag_q[s][w] <= '0;
        end
      end
      for (int i = 0; i < 5; i++) cnt_q[i] <= '0;
      a_ways    <= 3'd1;
      rsp_valid <= 1'b0;
      rsp_hit_a <= 1'b0;
      rsp_hit_b <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_way   <= 2'd0;
      rsp_pos   <= 2'd0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit_a <= hit && in_a;
        rsp_hit_b <= hit && !in_a && !a_only;
        rsp_miss  <= !hit || (!in_a && a_only);
        rsp_way   <= tgt_way;
        rsp_pos   <= tgt_pos;
        for (int p = 0; p < 4; p++) ord_q[lk_set][p] <= new_ord[p];
        if (!hit) begin
          tag_q[lk_set][tgt_way] <= lk_tag;
          vld_q[lk_set][tgt_way] <= 1'b1;
        end
      end
      for (int i = 0; i < 5; i++) begin
        if (interval_end)
          cnt_q[i] <= (lk_valid && inc_idx == 3'(i)) ? CNT_W'(1) : '0;
        else if (lk_valid && inc_idx == 3'(i) && cnt_q[i] != '1)
          cnt_q[i] <= cnt_q[i] + 1'b1;
      end
      if (interval_end) a_ways <= best_k;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit_a, rsp_hit_b, rsp_miss})); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R2
  AST_NO_B_WHEN_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && a_only) |=> !rsp_hit_b); // R4
  AST_MISS_AT_LRU: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !hit) |=> (rsp_miss && rsp_pos == 2'd3)); // R5
  AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ways >= 3'd1 && a_ways <= 3'd4)); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end |=> $stable(a_ways)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end |=> (cnt_q[0] >= $past(cnt_q[0]) && cnt_q[4] >= $past(cnt_q[4]))); // R9
endmodule

// File: tb/sim_acct_cache_ctrl.sv
module sim_acct_cache_ctrl;
  localparam int SETS = 16;
  localparam int AL [4] = '{2, 3, 4, 5};
  localparam int BL [4] = '{8, 5, 2, 0};
  localparam int MP = 40;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, a_only = 0, interval_end = 0;
  logic [3:0] lk_set = 0;
  logic [7:0] lk_tag = 0;
  logic rsp_valid, rsp_hit_a, rsp_hit_b, rsp_miss;
  logic [1:0] rsp_way, rsp_pos;
  logic [2:0] a_ways;

  acct_cache_ctrl u0 (.*);

  always #4 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int m_tag [SETS][4];
  bit m_val [SETS][4];
  int m_ord [SETS][4];
  int m_cnt [5];
  int m_cfg;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pick();
    longint best = 0, c, ah, bh;
    int bk = 1;
    for (int k = 0; k < 4; k++) begin
      ah = 0; bh = 0;
      for (int p = 0; p < 4; p++)
        if (p <= k) ah += m_cnt[p]; else bh += m_cnt[p];
      c = ah * AL[k] + bh * (AL[k] + BL[k]) + longint'(m_cnt[4]) * MP;
      if (k == 0 || c < best) begin best = c; bk = k + 1; end
    end
    return bk;
  endfunction

  task automatic step(bit lv, int s, int t, bit ao, bit ie);
    int w, p, e_way, e_pos, idx, ncfg;
    bit hit;
    bit e_a, e_b, e_m;
    w = -1; p = 3; hit = 0;
    e_a = 0; e_b = 0; e_m = 0; e_way = 0; e_pos = 0; idx = 4;
    lk_valid = lv; lk_set = 4'(s); lk_tag = 8'(t); a_only = ao; interval_end = ie;
    ncfg = ie ? pick() : m_cfg;
    if (lv) begin
      for (int i = 0; i < 4; i++) if (m_val[s][i] && m_tag[s][i] == t) begin hit = 1; w = i; end
      if (hit) for (int i = 0; i < 4; i++) if (m_ord[s][i] == w) p = i;
      if (!hit) begin w = m_ord[s][3]; p = 3; m_tag[s][w] = t; m_val[s][w] = 1; end
      if (hit && p < m_cfg) e_a = 1;
      else if (hit && !ao) e_b = 1;
      else e_m = 1;
      e_way = w; e_pos = p;
      for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
      m_ord[s][0] = w;
      idx = hit ? p : 4;
    end
    if (ie) for (int i = 0; i < 5; i++) m_cnt[i] = 0;
    if (lv && m_cnt[idx] < 65535) m_cnt[idx]++;
    m_cfg = ncfg;
    @(posedge clk); #1;
    chk("R2 rsp_valid", rsp_valid, lv);
    if (lv) begin
      chk(e_a ? "R2 hit_a" : "R2 hit_a clear", rsp_hit_a, e_a);
      chk(ao ? "R4 hit_b" : "R3 hit_b", rsp_hit_b, e_b);
      chk(hit ? "R4 miss" : "R5 miss", rsp_miss, e_m);
      chk("R6 rsp_way", rsp_way, e_way);
      chk(hit ? "R3 rsp_pos" : "R5 rsp_pos", rsp_pos, e_pos);
    end
    chk(ie ? "R7 a_ways select" : "R7 a_ways hold", a_ways, m_cfg);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 4; w++) begin m_val[s][w] = 0; m_tag[s][w] = 0; m_ord[s][w] = w; end
    for (int i = 0; i < 5; i++) m_cnt[i] = 0;
    m_cfg = 1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    chk("R1 reset a_ways", a_ways, 1);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    // R1: first lookups into an empty set miss; R5 victim is LRU
    for (int t = 1; t <= 4; t++) step(1, 0, t, 0, 0);
    // R2/R3/R6: hits at various recency positions with one primary way
    step(1, 0, 1, 0, 0);
    step(1, 0, 1, 0, 0);
    step(1, 0, 3, 0, 0);
    step(1, 0, 2, 0, 0);
    // R4: secondary probe disabled
    step(1, 0, 4, 1, 0);
    step(1, 0, 1, 1, 0);
    // R5: new tag evicts the least recent block
    step(1, 0, 9, 0, 0);
    step(1, 0, 2, 0, 0);
    // R7: close interval, then R8 an empty interval ties at zero -> 1 way
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 40; i++) step(1, 1, i % 4, 0, 0);
    step(1, 1, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    // mixed traffic across sets, modes and intervals
    for (int i = 0; i < 3000; i++)
      step(1, $urandom_range(0, 3), $urandom_range(0, 6), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 150) == 0));
    step(0, 0, 0, 0, 1);
    // R9: saturate position 0, then 2000 position-1 hits; saturated -> 1 way
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 70000; i++) step(1, 5, 7, 0, 0);
    for (int i = 0; i < 2000; i++) step(1, 5, (i % 2) ? 7 : 8, 0, 0);
    step(0, 0, 0, 0, 1);
    chk("R9 saturated selection", a_ways, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule